// File: doc/BRIEF.md
# Page-Buffered Byte Store Controller

This block is the memory side of a two-wire serial byte store. It sits behind a bus front end that decodes START, STOP, addressing and acknowledge. The front end reports what happened through single-cycle event pulses: a word address was received, a data byte was received, a STOP was seen, or the master wants the next read byte. The storage is a register file of 2048 bytes, seen as 128 pages of 16 bytes.

Incoming write data does not go straight into the array. It collects in a 16-entry page buffer, starting at the offset given by the loaded address. On STOP, every buffer entry that was actually loaded is committed to its page in one internal write operation. A timed busy period follows, and while it lasts the front end withholds its address acknowledge. A write-protect input, sampled at STOP, vetoes the commit. Reads stream bytes out from a separate read address, which advances after each byte and wraps around the whole array.

Top module: `page_eeprom_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `busy_o` and `rd_valid_o` are low. After reset every array byte reads as 8'hFF.
- R2: An accepted `addr_load_i` splits `addr_i` into a page (`addr_i[10:4]`) and a start offset (`addr_i[3:0]`). It also sets the read address to `addr_i`, so reads may run across page boundaries.
- R3: Each accepted `wr_byte_i` stores `wr_data_i` in the buffer entry at the current offset, then advances the offset. The offset wraps from 15 to 0 inside the same page, and a later byte replaces an earlier one in the same entry.
- R4: A commit writes only the buffer entries loaded since the last address load. All other bytes of the page, and all other pages, keep their contents.
- R5: A commit starts on an accepted `stop_i` only if at least one data byte was accepted since the last address load or STOP. A STOP with no data causes no busy period, and every STOP empties the buffer.
- R6: If `wp_i` is high in the cycle `stop_i` is accepted, there is no commit and no busy period, and the array is unchanged.
- R7: After a commit, `busy_o` is high for exactly WRITE_CYCLES clock cycles, starting in the cycle after the STOP was sampled.
- R8: While `busy_o` is high, `addr_load_i`, `wr_byte_i`, `stop_i` and `rd_req_i` are ignored. This covers address, buffer, read address and output state.
- R9: An accepted `rd_req_i` puts the byte at the read address on `rd_data_o` in the following cycle, with `rd_valid_o` high for that one cycle. The read address then advances by one.
- R10: The read address wraps from 2047 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_i | input | 1 | Write protect, sampled with the STOP event |
| addr_load_i | input | 1 | Pulse: word address received |
| addr_i | input | 11 | Word address, page in [10:4], offset in [3:0] |
| wr_byte_i | input | 1 | Pulse: write data byte received |
| wr_data_i | input | 8 | Write data byte |
| stop_i | input | 1 | Pulse: STOP seen on the bus |
| rd_req_i | input | 1 | Pulse: fetch the next read byte |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | Read byte valid, one cycle |
| busy_o | output | 1 | Internal write in progress; the front end must not acknowledge its address |

## Verification
A wrong buffer offset or a stale loaded mask does not show at once. It shows only after the commit busy period ends, when a read of the page returns a byte in the wrong slot, or a neighbour byte that was overwritten when it should have been kept. The bench therefore reads back whole pages, plus the bytes around them, after every write. A bad busy counter shows at the ports within the write cycle itself, as a busy window that is too short or too long. A read-address error shows one cycle after the affected request, as a wrong byte in the scoreboard. This is checked across a page edge and across the top-of-array wrap.

// File: rtl/pe_pkg.sv
package pe_pkg;
    localparam int unsigned ADDR_W = 11;
    localparam int unsigned OFS_W  = 4;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned PAGE_W = ADDR_W - OFS_W;
    localparam int unsigned SLOTS  = 1 << OFS_W;
    localparam int unsigned DEPTH  = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [DATA_W-1:0] data_t;

    localparam data_t ERASED = '1;

    typedef struct packed {
        logic  loaded;
        data_t data;
    } slot_t;

    typedef enum logic {WT_IDLE, WT_BUSY} wt_state_e;

    function automatic addr_t join_addr(page_t pg, ofs_t ofs);
        return {pg, ofs};
    endfunction

    function automatic addr_t addr_next(addr_t a);
        return a + 1'b1;
    endfunction
endpackage

// File: rtl/pe_page_buffer.sv
module pe_page_buffer
    import pe_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  ofs_t                    start_ofs_i,
    input  logic                    push_i,
    input  data_t                   push_data_i,
    input  logic                    drain_i,
    output slot_t [SLOTS-1:0]       slots_o,
    output logic                    has_data_o
);
    slot_t [SLOTS-1:0] slots_q;
    ofs_t              ptr_q;
    logic              has_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
            ptr_q   <= '0;
            has_q   <= 1'b0;
        end else if (start_i) begin
            for (int i = 0; i < SLOTS; i++) slots_q[i].loaded <= 1'b0;
            ptr_q <= start_ofs_i;
            has_q <= 1'b0;
        end else if (push_i) begin
            slots_q[ptr_q] <= '{loaded: 1'b1, data: push_data_i};
            ptr_q          <= ptr_q + 1'b1;
            has_q          <= 1'b1;
        end else if (drain_i) begin
            for (int i = 0; i < SLOTS; i++) slots_q[i].loaded <= 1'b0;
            has_q <= 1'b0;
        end
    end

    assign slots_o    = slots_q;
    assign has_data_o = has_q;
endmodule

// File: rtl/pe_write_timer.sv
module pe_write_timer
    import pe_pkg::*;
#(
    parameter int unsigned CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    wt_state_e       state_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WT_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                WT_IDLE: if (start_i) begin
                    state_q <= WT_BUSY;
                    cnt_q   <= CW'(CYCLES - 1);
                end
                WT_BUSY: begin
                    if (cnt_q == '0) state_q <= WT_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= WT_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q == WT_BUSY);
endmodule

// File: rtl/pe_mem_array.sv
module pe_mem_array
    import pe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_i,
    input  page_t             page_i,
    input  slot_t [SLOTS-1:0] slots_i,
    input  logic              rd_en_i,
    input  addr_t             rd_addr_i,
    output data_t             rd_data_o
);
    data_t mem_q [DEPTH];
    data_t rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) mem_q[a] <= ERASED;
            rd_q <= ERASED;
        end else begin
            if (commit_i) begin
                for (int i = 0; i < SLOTS; i++) begin
                    if (slots_i[i].loaded)
                        mem_q[join_addr(page_i, ofs_t'(i))] <= slots_i[i].data;
                end
            end
            if (rd_en_i) rd_q <= mem_q[rd_addr_i];
        end
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/page_eeprom_ctrl.sv
module page_eeprom_ctrl
    import pe_pkg::*;
#(
    parameter int unsigned WRITE_CYCLES = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wp_i,
    input  logic                addr_load_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_byte_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic                stop_i,
    input  logic                rd_req_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                rd_valid_o,
    output logic                busy_o
);
    slot_t [SLOTS-1:0] slots;
    logic              has_data;
    logic              load_ok, push_ok, stop_ok, rd_ok, commit;
    page_t             page_q;
    addr_t             rd_addr_q;
    logic              rd_valid_q;

    assign load_ok = addr_load_i & ~busy_o;
    assign push_ok = wr_byte_i   & ~busy_o;
    assign stop_ok = stop_i      & ~busy_o;
    assign rd_ok   = rd_req_i    & ~busy_o;
    assign commit  = stop_ok & has_data & ~wp_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q     <= '0;
            rd_addr_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_ok;
            if (load_ok) begin
                page_q    <= addr_i[ADDR_W-1:OFS_W];
                rd_addr_q <= addr_i;
            end else if (rd_ok) begin
                rd_addr_q <= addr_next(rd_addr_q);
            end
        end
    end

    pe_page_buffer u_buf (
        .clk         (clk),
        .rst         (rst),
        .start_i     (load_ok),
        .start_ofs_i (addr_i[OFS_W-1:0]),
        .push_i      (push_ok),
        .push_data_i (wr_data_i),
        .drain_i     (stop_ok),
        .slots_o     (slots),
        .has_data_o  (has_data)
    );

    pe_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (commit),
        .busy_o  (busy_o)
    );

    pe_mem_array u_mem (
        .clk       (clk),
        .rst       (rst),
        .commit_i  (commit),
        .page_i    (page_q),
        .slots_i   (slots),
        .rd_en_i   (rd_ok),
        .rd_addr_i (rd_addr_q),
        .rd_data_o (rd_data_o)
    );

    assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/page_eeprom_ctrl_sva.sv
module page_eeprom_ctrl_sva #(
    parameter int unsigned WRITE_CYCLES = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          wp_i,
    input logic          addr_load_i,
    input logic          stop_i,
    input logic          rd_req_i,
    input logic          busy_o,
    input logic          rd_valid_o,
    input pe_pkg::addr_t rd_addr_q
);
    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (rst)         busy_run <= 0;
        else if (busy_o) busy_run <= busy_run + 1;
        else             busy_run <= 0;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!busy_o && !rd_valid_o));

    assert_commit_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ($past(stop_i) && !$past(wp_i)));

    assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (stop_i && wp_i && !busy_o) |=> !busy_o);

    assert_busy_len_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (busy_run == WRITE_CYCLES));

    assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && rd_req_i) |=> !rd_valid_o);

    assert_read_valid_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && !busy_o) |=> rd_valid_o);

    assert_addr_step_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && !busy_o && !addr_load_i) |=>
            (rd_addr_q == pe_pkg::addr_t'($past(rd_addr_q) + 1'b1)));
endmodule

bind page_eeprom_ctrl page_eeprom_ctrl_sva #(.WRITE_CYCLES(WRITE_CYCLES)) u_sva (.*);

// File: tb/page_eeprom_ctrl_tb_top.sv
`timescale 1ns/1ps
module page_eeprom_ctrl_tb_top;
    import pe_pkg::*;
    localparam int unsigned WC = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wp_i = 1'b0, addr_load_i = 1'b0, wr_byte_i = 1'b0;
    logic        stop_i = 1'b0, rd_req_i = 1'b0;
    addr_t       addr_i = '0;
    data_t       wr_data_i = '0;
    data_t       rd_data_o;
    logic        rd_valid_o, busy_o;

    always #2.5 clk = ~clk;

    page_eeprom_ctrl #(.WRITE_CYCLES(WC)) dut_i (
        .clk(clk), .rst(rst), .wp_i(wp_i), .addr_load_i(addr_load_i),
        .addr_i(addr_i), .wr_byte_i(wr_byte_i), .wr_data_i(wr_data_i),
        .stop_i(stop_i), .rd_req_i(rd_req_i), .rd_data_o(rd_data_o),
        .rd_valid_o(rd_valid_o), .busy_o(busy_o)
    );

    data_t model [DEPTH];
    data_t q_exp [$];
    string q_tag [$];
    addr_t tb_raddr;
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rd_valid_o) begin
            if (q_exp.size() == 0) begin
                check(1'b0, "R8", "unexpected read byte", int'(rd_data_o), 0);
            end else begin
                automatic data_t e = q_exp.pop_front();
                automatic string t = q_tag.pop_front();
                check(rd_data_o === e, t, "read data", int'(rd_data_o), int'(e));
            end
        end
    end

    task automatic load_addr(input addr_t a, input bit track);
        @(negedge clk); addr_i = a; addr_load_i = 1'b1;
        @(negedge clk); addr_load_i = 1'b0;
        if (track) tb_raddr = a;
    endtask

    task automatic write_byte(input data_t d);
        @(negedge clk); wr_data_i = d; wr_byte_i = 1'b1;
        @(negedge clk); wr_byte_i = 1'b0;
    endtask

    task automatic stop_pulse();
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic read_n(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            q_exp.push_back(model[tb_raddr]);
            q_tag.push_back(tag);
            tb_raddr = tb_raddr + 1'b1;
            rd_req_i = 1'b1;
        end
        @(negedge clk); rd_req_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic measure_busy(input int exp, input string tag);
        int cnt = 0;
        while (busy_o && cnt < 500) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == exp, tag, "busy length", cnt, exp);
    endtask

    // page write with bench-side model of the buffer (R3, R4, R5, R6)
    task automatic do_write(input addr_t a, input int n, input data_t seed,
                            input bit wp, input bit measure);
        data_t pbuf [SLOTS];
        bit    ld   [SLOTS];
        ofs_t  ptr = a[OFS_W-1:0];
        for (int i = 0; i < SLOTS; i++) ld[i] = 1'b0;
        load_addr(a, 1'b1);
        for (int k = 0; k < n; k++) begin
            automatic data_t d = data_t'(seed + k * 7);
            pbuf[ptr] = d;
            ld[ptr]   = 1'b1;
            ptr       = ptr + 1'b1;
            write_byte(d);
        end
        wp_i = wp;
        stop_pulse();
        wp_i = 1'b0;
        if (n > 0 && !wp) begin
            for (int i = 0; i < SLOTS; i++)
                if (ld[i]) model[join_addr(a[ADDR_W-1:OFS_W], ofs_t'(i))] = pbuf[i];
        end
        if (measure) begin
            if (wp)         measure_busy(0, "R6");
            else if (n == 0) measure_busy(0, "R5");
            else            measure_busy(WC, "R7");
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1", "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) model[a] = ERASED;
        tb_raddr = '0;
        repeat (4) @(negedge clk);
        check(busy_o == 1'b0, "R1", "busy during reset", int'(busy_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o == 1'b0, "R1", "busy after reset", int'(busy_o), 0);
        check(rd_valid_o == 1'b0, "R1", "rd_valid after reset", int'(rd_valid_o), 0);
        load_addr(11'h000, 1'b1);
        read_n(4, "R1");

        // partial page write, neighbours keep erased value
        do_write(11'h123, 4, 8'h10, 1'b0, 1'b1);
        load_addr(11'h11E, 1'b1);
        read_n(20, "R4");

        // overflow wraps inside the page
        do_write(11'h2FE, 18, 8'h40, 1'b0, 1'b1);
        load_addr(11'h2F0, 1'b1);
        read_n(16, "R3");

        // second partial write keeps earlier bytes of the page
        do_write(11'h125, 2, 8'h80, 1'b0, 1'b1);
        load_addr(11'h120, 1'b1);
        read_n(16, "R4");

        // write protect
        do_write(11'h400, 3, 8'hA0, 1'b1, 1'b1);
        load_addr(11'h400, 1'b1);
        read_n(4, "R6");

        // STOP with no data
        do_write(11'h600, 0, 8'h00, 1'b0, 1'b1);

        // events during busy are ignored
        do_write(11'h130, 2, 8'hC0, 1'b0, 1'b0);
        check(busy_o == 1'b1, "R7", "busy right after STOP", int'(busy_o), 1);
        load_addr(11'h500, 1'b0);
        write_byte(8'h77);
        @(negedge clk); rd_req_i = 1'b1;
        @(negedge clk); rd_req_i = 1'b0;
        check(rd_valid_o == 1'b0, "R8", "read answered while busy", int'(rd_valid_o), 0);
        stop_pulse();
        check(busy_o == 1'b1, "R8", "busy still counting", int'(busy_o), 1);
        while (busy_o) @(negedge clk);
        stop_pulse();
        check(busy_o == 1'b0, "R8", "stray byte committed", int'(busy_o), 0);
        read_n(3, "R8");
        load_addr(11'h500, 1'b1);
        read_n(2, "R8");

        // read handshake timing
        load_addr(11'h123, 1'b1);
        @(negedge clk);
        q_exp.push_back(model[tb_raddr]); q_tag.push_back("R9");
        tb_raddr = tb_raddr + 1'b1;
        rd_req_i = 1'b1;
        @(negedge clk); rd_req_i = 1'b0;
        check(rd_valid_o == 1'b1, "R9", "valid one cycle after request", int'(rd_valid_o), 1);
        @(negedge clk);
        check(rd_valid_o == 1'b0, "R9", "valid is a single pulse", int'(rd_valid_o), 0);
        read_n(2, "R9");

        // read crossing a page edge
        load_addr(11'h2F8, 1'b1);
        read_n(12, "R2");

        // read wrap at the top of the array
        do_write(11'h7FF, 1, 8'h55, 1'b0, 1'b1);
        do_write(11'h000, 1, 8'h66, 1'b0, 1'b1);
        load_addr(11'h7FE, 1'b1);
        read_n(4, "R10");

        repeat (4) @(negedge clk);
        check(q_exp.size() == 0, "R9", "reads outstanding", q_exp.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule